// File: doc/BRIEF.md
# System Timebase Counter

This block is a chip-level timebase. A 64-bit count advances on strobes from one of two tick sources: a base-rate strobe and an alternate-rate strobe. Software picks the source through a pair of request bits in a control word. It can also hand that choice to an external request pin. The source actually in use is reported by an acknowledge flag, which trails the effective request by a short register pipe. Software polls that flag before it relies on a mode change.

The count can be frozen while a debug session is active. Software can also overwrite it, one 32-bit half at a time. Two independent compare frames each hold a 64-bit threshold and an enable bit. A frame reports a match while the count has reached its threshold, and it raises an interrupt unless that interrupt is masked. Thresholds can only be loaded while the base source is in use. All state is reached through a single-cycle 32-bit word-addressed register port with combinational read data.

Top module: `tbase_top`

## Requirements
- R1: After reset:
  - the control word reads 0x00000100;
  - the second control word, the status word, both count halves and all compare words read 0;
  - `cmp_irq` is 0 and `alt_active` is 0.
- R2: In base mode with the enable bit set, the count rises by exactly 1 on each cycle where `base_tick` is high. A carry from the low half reaches the high half. With the enable bit clear, the count does not change.
- R3: In alternate mode, only `alt_tick` advances the count and `base_tick` has no effect. In base mode, `alt_tick` has no effect.
- R4: When the halt bit is set and `dbg_active` is high, ticks do not advance the count. When `dbg_active` is high but the halt bit is clear, counting continues.
- R5: `alt_active` and status bit 0 equal the effective alternate request delayed by two clock cycles. After a control write, the new value is visible after the second rising edge that follows the write edge. The effective request is req_alt AND NOT req_base.
- R6: When bit 0 of the second control word is set, the `hw_alt_req` pin is the effective request (1 = alternate) and the software request bits have no effect.
- R7: A write to word 3 replaces count bits 31:0, and a write to word 4 replaces bits 63:32. Such a write takes precedence over a tick in the same cycle.
- R8: Words 5, 6 and 7 are read-only and return the tick rate of each mode: 24000000, 32768 and 0. Writes to them are ignored.
- R9: Compare frame k has these words:
  - threshold low half at 8+4k;
  - threshold high half at 9+4k;
  - frame control at 10+4k, with bit 0 = enable, bit 1 = mask and bit 2 = read-only match status.
  
  The status is 1 while the frame is enabled and count >= threshold. `cmp_irq[k]` is status AND NOT mask, and it reflects a new threshold from the cycle after the write.
- R10: A write to either threshold word is ignored while `alt_active` is 1.
- R11: The two compare frames are independent. Writing or matching one frame does not change the other frame's words or its interrupt.
- R12: Control word 0 has bit 0 = count enable, bit 1 = debug halt, bit 8 = req_base and bit 9 = req_alt. Word 1 bit 0 hands mode selection to the pin. Word 2 bit 0 is the acknowledge flag. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Base-rate count strobe |
| alt_tick | input | 1 | Alternate-rate count strobe |
| dbg_active | input | 1 | Debug session active |
| hw_alt_req | input | 1 | External request for alternate mode |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (5) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| alt_active | output | 1 | Alternate mode acknowledged |
| count_val | output | 64 | Current count |
| cmp_irq | output | NUM_FRAMES (2) | Per-frame compare interrupt |

## Verification
A wrong step decision shows on `count_val` one cycle after the strobe concerned. A drifting count then stays visibly wrong on every later cycle, because the count never resynchronises. A fault in the acknowledge pipe shows as a status flip one edge early or late, and it makes strobes of the wrong source count during that window. A corrupted threshold or frame control shows on `cmp_irq` in the cycle after the offending write, or at the first tick that crosses the threshold.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    // Word addresses of the register port
    localparam int unsigned A_CTRL       = 0;
    localparam int unsigned A_CTRL2      = 1;
    localparam int unsigned A_STAT       = 2;
    localparam int unsigned A_CNT_LO     = 3;
    localparam int unsigned A_CNT_HI     = 4;
    localparam int unsigned A_FID_BASE   = 5;
    localparam int unsigned NUM_FID      = 3;
    localparam int unsigned A_FRAME0     = 8;
    localparam int unsigned FRAME_STRIDE = 4;
    localparam int unsigned OFF_THR_LO   = 0;
    localparam int unsigned OFF_THR_HI   = 1;
    localparam int unsigned OFF_FCTL     = 2;

    // Control bit positions (software visible)
    localparam int unsigned B_EN       = 0;
    localparam int unsigned B_HALT     = 1;
    localparam int unsigned B_REQ_BASE = 8;
    localparam int unsigned B_REQ_ALT  = 9;

    typedef enum logic {
        MODE_BASE = 1'b0,
        MODE_ALT  = 1'b1
    } mode_e;

    typedef struct packed {
        logic en;
        logic halt;
        logic req_base;
        logic req_alt;
    } ctrl_t;

    typedef struct packed {
        logic en;
        logic mask;
    } fctl_t;

    typedef struct packed {
        logic thr_lo;
        logic thr_hi;
        logic fctl;
    } fwr_t;

    localparam ctrl_t CTRL_RESET = '{en: 1'b0, halt: 1'b0, req_base: 1'b1, req_alt: 1'b0};

    function automatic logic [31:0] ctrl_to_word(ctrl_t c);
        logic [31:0] w;
        w             = '0;
        w[B_EN]       = c.en;
        w[B_HALT]     = c.halt;
        w[B_REQ_BASE] = c.req_base;
        w[B_REQ_ALT]  = c.req_alt;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(logic [31:0] w);
        ctrl_t c;
        c.en       = w[B_EN];
        c.halt     = w[B_HALT];
        c.req_base = w[B_REQ_BASE];
        c.req_alt  = w[B_REQ_ALT];
        return c;
    endfunction

    function automatic logic want_alt_sw(ctrl_t c);
        return c.req_alt & ~c.req_base;
    endfunction

    function automatic int unsigned frame_addr(int unsigned k, int unsigned off);
        return A_FRAME0 + k * FRAME_STRIDE + off;
    endfunction

endpackage

// File: rtl/tbase_counter.sv
module tbase_counter
    import tbase_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  ctrl_t       ctrl,
    input  logic        hw_sel,
    input  logic        hw_alt_req,
    input  logic        base_tick,
    input  logic        alt_tick,
    input  logic        dbg_active,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output logic [63:0] count,
    output logic        alt_active
);

    localparam int unsigned ACK_STAGES = 2;

    logic                  want_alt;
    logic [ACK_STAGES-1:0] ack_pipe;
    mode_e                 mode;
    logic                  tick_sel;
    logic                  step;
    logic [63:0]           count_next;

    assign want_alt   = hw_sel ? hw_alt_req : want_alt_sw(ctrl);
    assign alt_active = ack_pipe[ACK_STAGES-1];
    assign mode       = alt_active ? MODE_ALT : MODE_BASE;

    always_ff @(posedge clk) begin
        if (rst) ack_pipe <= '0;
        else     ack_pipe <= {ack_pipe[ACK_STAGES-2:0], want_alt};
    end

    always_comb begin
        unique case (mode)
            MODE_ALT:  tick_sel = alt_tick;
            default:   tick_sel = base_tick;
        endcase
        step = ctrl.en && tick_sel && !(ctrl.halt && dbg_active);
    end

    always_comb begin
        if (wr_lo)      count_next = {count[63:32], wdata};
        else if (wr_hi) count_next = {wdata, count[31:0]};
        else            count_next = count + 64'(step);
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count_next;
    end

    // Cycles since reset, saturating; used to keep history checks inside valid time
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_lo && !wr_hi) |=> (count == $past(count) + 64'd1));

    a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !wr_lo && !wr_hi) |=> $stable(count));

    a_r4_debug_freeze: assert property (@(posedge clk) disable iff (rst)
        (ctrl.halt && dbg_active && !wr_lo && !wr_hi) |=> $stable(count));

    a_r5_ack_delay: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (alt_active == $past(want_alt, 2)));

    a_r7_low_write: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (count[31:0] == $past(wdata)));

endmodule

// File: rtl/tbase_cmp_frame.sv
module tbase_cmp_frame
    import tbase_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  fwr_t        wr,
    input  logic [31:0] wdata,
    input  logic        alt_active,
    input  logic [63:0] count,
    output logic [31:0] thr_lo_word,
    output logic [31:0] thr_hi_word,
    output logic [31:0] fctl_word,
    output logic        irq
);

    logic [63:0] thr;
    fctl_t       fctl;
    logic        status;
    logic        thr_open;

    assign thr_open = !alt_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr  <= '0;
            fctl <= '0;
        end else begin
            if (wr.thr_lo && thr_open) thr[31:0]  <= wdata;
            if (wr.thr_hi && thr_open) thr[63:32] <= wdata;
            if (wr.fctl) begin
                fctl.en   <= wdata[0];
                fctl.mask <= wdata[1];
            end
        end
    end

    assign status      = fctl.en && (count >= thr);
    assign irq         = status && !fctl.mask;
    assign thr_lo_word = thr[31:0];
    assign thr_hi_word = thr[63:32];
    assign fctl_word   = {29'd0, status, fctl.mask, fctl.en};

    a_r10_lock_lo: assert property (@(posedge clk) disable iff (rst)
        (alt_active && wr.thr_lo) |=> $stable(thr_lo_word));

    a_r10_lock_hi: assert property (@(posedge clk) disable iff (rst)
        (alt_active && wr.thr_hi) |=> $stable(thr_hi_word));

    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr.fctl && wdata[1]) |=> !irq);

endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
    import tbase_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned NUM_FRAMES = 2,
    parameter logic [31:0] FREQ_ID0   = 32'd24000000,
    parameter logic [31:0] FREQ_ID1   = 32'd32768,
    parameter logic [31:0] FREQ_ID2   = 32'd0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output ctrl_t                        ctrl,
    output logic                         hw_sel,
    input  logic                         alt_active,
    input  logic [63:0]                  count,
    output logic                         cnt_wr_lo,
    output logic                         cnt_wr_hi,
    output fwr_t [NUM_FRAMES-1:0]        frm_wr,
    input  logic [NUM_FRAMES-1:0][31:0]  frm_lo,
    input  logic [NUM_FRAMES-1:0][31:0]  frm_hi,
    input  logic [NUM_FRAMES-1:0][31:0]  frm_ctl
);

    localparam int unsigned LAST_ADDR = A_FRAME0 + NUM_FRAMES * FRAME_STRIDE - 1;

    initial begin
        if (LAST_ADDR >= (1 << ADDR_W))
            $error("ADDR_W too small for NUM_FRAMES");
    end

    function automatic logic [31:0] fid_value(int unsigned i);
        case (i)
            0:       return FREQ_ID0;
            1:       return FREQ_ID1;
            default: return FREQ_ID2;
        endcase
    endfunction

    function automatic logic hit(logic [ADDR_W-1:0] a, int unsigned target);
        return a == ADDR_W'(target);
    endfunction

    logic wr_ctrl, wr_ctrl2;

    assign wr_ctrl   = bus_wr && hit(bus_addr, A_CTRL);
    assign wr_ctrl2  = bus_wr && hit(bus_addr, A_CTRL2);
    assign cnt_wr_lo = bus_wr && hit(bus_addr, A_CNT_LO);
    assign cnt_wr_hi = bus_wr && hit(bus_addr, A_CNT_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= CTRL_RESET;
            hw_sel <= 1'b0;
        end else begin
            if (wr_ctrl)  ctrl   <= word_to_ctrl(bus_wdata);
            if (wr_ctrl2) hw_sel <= bus_wdata[0];
        end
    end

    for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_frame_dec
        assign frm_wr[k].thr_lo = bus_wr && hit(bus_addr, frame_addr(k, OFF_THR_LO));
        assign frm_wr[k].thr_hi = bus_wr && hit(bus_addr, frame_addr(k, OFF_THR_HI));
        assign frm_wr[k].fctl   = bus_wr && hit(bus_addr, frame_addr(k, OFF_FCTL));
    end

    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, A_CTRL))   bus_rdata = ctrl_to_word(ctrl);
        if (hit(bus_addr, A_CTRL2))  bus_rdata = {31'd0, hw_sel};
        if (hit(bus_addr, A_STAT))   bus_rdata = {31'd0, alt_active};
        if (hit(bus_addr, A_CNT_LO)) bus_rdata = count[31:0];
        if (hit(bus_addr, A_CNT_HI)) bus_rdata = count[63:32];
        for (int unsigned i = 0; i < NUM_FID; i++) begin
            if (hit(bus_addr, A_FID_BASE + i)) bus_rdata = fid_value(i);
        end
        for (int unsigned k = 0; k < NUM_FRAMES; k++) begin
            if (hit(bus_addr, frame_addr(k, OFF_THR_LO))) bus_rdata = frm_lo[k];
            if (hit(bus_addr, frame_addr(k, OFF_THR_HI))) bus_rdata = frm_hi[k];
            if (hit(bus_addr, frame_addr(k, OFF_FCTL)))   bus_rdata = frm_ctl[k];
        end
    end

    a_r12_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl.req_alt == $past(bus_wdata[B_REQ_ALT])));

endmodule

// File: rtl/tbase_top.sv
module tbase_top
    import tbase_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned NUM_FRAMES = 2,
    parameter logic [31:0] FREQ_ID0   = 32'd24000000,
    parameter logic [31:0] FREQ_ID1   = 32'd32768,
    parameter logic [31:0] FREQ_ID2   = 32'd0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  base_tick,
    input  logic                  alt_tick,
    input  logic                  dbg_active,
    input  logic                  hw_alt_req,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  alt_active,
    output logic [63:0]           count_val,
    output logic [NUM_FRAMES-1:0] cmp_irq
);

    ctrl_t                        ctrl;
    logic                         hw_sel;
    logic                         cnt_wr_lo, cnt_wr_hi;
    fwr_t [NUM_FRAMES-1:0]        frm_wr;
    logic [NUM_FRAMES-1:0][31:0]  frm_lo, frm_hi, frm_ctl;

    tbase_regs #(
        .ADDR_W     (ADDR_W),
        .NUM_FRAMES (NUM_FRAMES),
        .FREQ_ID0   (FREQ_ID0),
        .FREQ_ID1   (FREQ_ID1),
        .FREQ_ID2   (FREQ_ID2)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ctrl       (ctrl),
        .hw_sel     (hw_sel),
        .alt_active (alt_active),
        .count      (count_val),
        .cnt_wr_lo  (cnt_wr_lo),
        .cnt_wr_hi  (cnt_wr_hi),
        .frm_wr     (frm_wr),
        .frm_lo     (frm_lo),
        .frm_hi     (frm_hi),
        .frm_ctl    (frm_ctl)
    );

    tbase_counter u_counter (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .hw_sel     (hw_sel),
        .hw_alt_req (hw_alt_req),
        .base_tick  (base_tick),
        .alt_tick   (alt_tick),
        .dbg_active (dbg_active),
        .wr_lo      (cnt_wr_lo),
        .wr_hi      (cnt_wr_hi),
        .wdata      (bus_wdata),
        .count      (count_val),
        .alt_active (alt_active)
    );

    for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_frame
        tbase_cmp_frame u_frame (
            .clk         (clk),
            .rst         (rst),
            .wr          (frm_wr[k]),
            .wdata       (bus_wdata),
            .alt_active  (alt_active),
            .count       (count_val),
            .thr_lo_word (frm_lo[k]),
            .thr_hi_word (frm_hi[k]),
            .fctl_word   (frm_ctl[k]),
            .irq         (cmp_irq[k])
        );
    end

endmodule

// File: tb/sim_tbase_top.sv
`timescale 1ns/1ps
module sim_tbase_top;

    localparam int AW = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_tick = 1'b0, alt_tick = 1'b0, dbg_active = 1'b0, hw_alt_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alt_active;
    logic [63:0] count_val;
    logic [1:0]  cmp_irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] exp_cnt;
    logic [31:0] rv;

    always #4 clk = ~clk;

    tbase_top u0 (
        .clk(clk), .rst(rst), .base_tick(base_tick), .alt_tick(alt_tick),
        .dbg_active(dbg_active), .hw_alt_req(hw_alt_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alt_active(alt_active), .count_val(count_val), .cmp_irq(cmp_irq)
    );

    function automatic logic [31:0] ctl(bit en, bit halt, bit rb, bit ra);
        return {22'd0, ra, rb, 6'd0, halt, en};
    endfunction

    function automatic logic [63:0] model_step(logic [63:0] c, bit en, bit halt, bit dbg, bit tick);
        return (en && tick && !(halt && dbg)) ? c + 64'd1 : c;
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic edge1();
        @(posedge clk); #1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        edge1();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_base(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); base_tick = 1'b1;
            edge1();
            base_tick = 1'b0;
        end
    endtask

    task automatic pulse_alt(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); alt_tick = 1'b1;
            edge1();
            alt_tick = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) edge1();
        @(negedge clk); rst = 1'b0;
        edge1();

        // R1 reset state
        rd(0, rv);  chk("R1 ctrl", rv, 32'h100);
        rd(1, rv);  chk("R1 ctrl2", rv, 0);
        rd(2, rv);  chk("R1 stat", rv, 0);
        chk("R1 count", count_val, 0);
        rd(10, rv); chk("R1 frame0 ctl", rv, 0);
        rd(13, rv); chk("R1 frame1 thr hi", rv, 0);
        chk("R1 irq", {62'd0, cmp_irq}, 0);

        // R2 disabled: no count
        pulse_base(3);
        chk("R2 disabled", count_val, 0);
        wr(0, ctl(1, 0, 1, 0));
        pulse_base(5);
        chk("R2 five ticks", count_val, 5);

        // R2 carry, R7 low write
        wr(3, 32'hFFFF_FFFF);
        chk("R7 low write", count_val, 64'h0000_0000_FFFF_FFFF);
        pulse_base(1);
        rd(4, rv); chk("R2 carry hi", rv, 1);
        rd(3, rv); chk("R2 carry lo", rv, 0);

        // R7 write wins over same-cycle tick
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(3); bus_wdata = 32'd7; base_tick = 1'b1;
        edge1();
        bus_wr = 1'b0; base_tick = 1'b0;
        chk("R7 write beats tick", count_val, 64'h1_0000_0007);
        wr(4, 0);
        chk("R7 high write", count_val, 7);

        // R4 debug halt
        wr(0, ctl(1, 1, 1, 0));
        dbg_active = 1'b1;
        pulse_base(4);
        chk("R4 halted", count_val, 7);
        dbg_active = 1'b0;
        pulse_base(2);
        chk("R4 halt bit without debug", count_val, 9);
        wr(0, ctl(1, 0, 1, 0));
        dbg_active = 1'b1;
        pulse_base(1);
        chk("R4 debug without halt bit", count_val, 10);
        dbg_active = 1'b0;

        // R9 / R11 compare frames
        wr(3, 100);
        wr(8, 103);
        wr(9, 0);
        wr(10, 32'h1);
        chk("R9 below threshold", {62'd0, cmp_irq}, 0);
        rd(10, rv); chk("R9 status clear", rv, 32'h1);
        pulse_base(3);
        chk("R9 reached threshold irq", {62'd0, cmp_irq}, 1);
        rd(10, rv); chk("R9 status set", rv, 32'h5);
        wr(10, 32'h3);
        chk("R9 masked irq", {62'd0, cmp_irq}, 0);
        rd(10, rv); chk("R9 masked status", rv, 32'h7);
        wr(14, 32'h1);
        chk("R11 frame1 alone", {62'd0, cmp_irq}, 2);
        wr(13, 1);
        chk("R11 frame1 new threshold", {62'd0, cmp_irq}, 0);
        rd(8, rv); chk("R11 frame0 threshold kept", rv, 103);
        wr(10, 32'h1);
        chk("R9 unmask", {62'd0, cmp_irq}, 1);

        // R5 acknowledge delay into alternate mode
        wr(0, ctl(1, 0, 0, 1));
        rd(2, rv); chk("R5 stat at write edge", rv, 0);
        edge1();
        rd(2, rv); chk("R5 stat after one edge", rv, 0);
        edge1();
        rd(2, rv); chk("R5 stat after two edges", rv, 1);
        chk("R5 alt_active pin", {63'd0, alt_active}, 1);

        // R3 alternate source only
        pulse_base(4);
        chk("R3 base ignored in alt", count_val, 103);
        pulse_alt(2);
        chk("R3 alt counts", count_val, 105);

        // R10 threshold writes ignored while alternate active
        wr(8, 5);
        rd(8, rv); chk("R10 lo locked", rv, 103);
        wr(9, 7);
        rd(9, rv); chk("R10 hi locked", rv, 0);
        chk("R10 irq unchanged", {62'd0, cmp_irq}, 1);

        // R5 back to base
        wr(0, ctl(1, 0, 1, 0));
        edge1();
        rd(2, rv); chk("R5 still alt after one edge", rv, 1);
        edge1();
        rd(2, rv); chk("R5 base after two edges", rv, 0);
        pulse_alt(3);
        chk("R3 alt ignored in base", count_val, 105);
        wr(8, 200);
        rd(8, rv); chk("R10 write accepted in base", rv, 200);
        chk("R9 irq after raise", {62'd0, cmp_irq}, 0);

        // R6 pin-driven mode
        wr(1, 1);
        wr(0, ctl(1, 0, 0, 1));
        repeat (3) edge1();
        rd(2, rv); chk("R6 software request ignored", rv, 0);
        @(negedge clk); hw_alt_req = 1'b1;
        edge1();
        rd(2, rv); chk("R6 pin one edge", rv, 0);
        edge1();
        rd(2, rv); chk("R6 pin selects alt", rv, 1);
        @(negedge clk); hw_alt_req = 1'b0;
        edge1(); edge1();
        rd(2, rv); chk("R6 pin back to base", rv, 0);
        wr(1, 0);
        edge1(); edge1();
        rd(2, rv); chk("R6 software regains control", rv, 1);
        wr(0, ctl(1, 0, 1, 0));
        repeat (3) edge1();

        // R8 frequency IDs
        rd(5, rv); chk("R8 fid0", rv, 24000000);
        rd(6, rv); chk("R8 fid1", rv, 32768);
        rd(7, rv); chk("R8 fid2", rv, 0);
        wr(5, 32'h1234);
        rd(5, rv); chk("R8 fid0 write ignored", rv, 24000000);

        // R12 layout and unmapped words
        rd(0, rv);  chk("R12 ctrl layout", rv, 32'h101);
        rd(15, rv); chk("R12 unmapped 15", rv, 0);
        rd(31, rv); chk("R12 unmapped 31", rv, 0);

        // R2 / R4 random phases
        for (int ph = 0; ph < 4; ph++) begin
            bit halt;
            halt = ph[0];
            wr(0, ctl(0, 0, 1, 0));
            wr(3, 32'hFFFF_FF00 + 32'(ph));
            wr(4, 32'(ph));
            wr(0, ctl(1, halt, 1, 0));
            exp_cnt = {32'(ph), 32'hFFFF_FF00 + 32'(ph)};
            for (int i = 0; i < 300; i++) begin
                bit t, d;
                t = 1'($urandom % 2);
                d = 1'($urandom % 2);
                @(negedge clk);
                base_tick = t; dbg_active = d; alt_tick = 1'($urandom % 2);
                edge1();
                exp_cnt = model_step(exp_cnt, 1'b1, halt, d, t);
                chk(halt ? "R4 random halt" : "R2 random count", count_val, exp_cnt);
            end
            base_tick = 1'b0; dbg_active = 1'b0; alt_tick = 1'b0;
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule